// File: doc/BRIEF.md
# PCI interrupt line router

The router takes four shared PCI interrupt request lines, A to D, and steers each one onto one of sixteen legacy interrupt controller inputs. Each line has a byte-wide routing register. A routing value below 16 names the target input. Any larger value parks the line, so its level reaches no output. When several lines share one input, the block drives that input with the OR of their levels. The controller outputs are registered. They follow a change in level or in routing one clock later.

A 32-bit configuration port with byte enables holds the four routing bytes. Beside it sit two combinational helpers. One is a routing query, which reports for a given line whether it is enabled and, if so, its input number. The other is a slot mapper, which turns a device number and INTx pin into the request line that the pin shares. A separate one-byte reset-control port keeps the reset-type bit, and on command it issues a one-cycle system-reset request.

Top module: `pirq_router`

## Requirements
- R1: The four routing bytes sit in the configuration dword at byte offset 0x60 (`cfg_addr_i` = 0x18). Byte lane i (bits 8i+7:8i) belongs to line i, with A=0, B=1, C=2, D=3. A write updates only the lanes whose `cfg_be_i` bit is set. A read of that dword returns the stored bytes. Writes to any other dword change nothing, and reads of them return 0.
- R2: A routing byte below 16 sends its line to `irq_o[byte]`. A byte of 16 or more disables the line, so its level reaches no output.
- R3: After reset every routing byte reads 0x80, and `irq_o` is all zero.
- R4: `irq_o[k]` is the OR of the `req_i` bits of every line routed to k. It is registered, so it reflects a level change or a routing write one clock after the edge that samples it.
- R5: When two lines share one input, that input stays high until both requests drop.
- R6: `line_o` = (`intx_i` + `dev_i` − 1) mod 4. Here `dev_i` is the device number (devfn bits 7:3), and INTA=0 to INTD=3.
- R7: A reset-control write with bit 2 set drives `sys_rst_req_o` high for exactly the next cycle and leaves the stored byte unchanged.
- R8: A reset-control write with bit 2 clear stores only bit 1, and all other stored bits read 0. `rst_rdata_o` returns the stored byte, which resets to 0.
- R9: For the line on `q_pin_i`, `q_en_o` is 1 and `q_irq_o` holds the routing byte when that byte is below 16. Otherwise `q_en_o` is 0 and `q_irq_o` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request line levels, A=bit 0 |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be_i | input | 4 | Byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` |
| irq_o | output | 16 | Legacy controller inputs |
| q_pin_i | input | 2 | Line to query |
| q_en_o | output | 1 | Queried line enabled |
| q_irq_o | output | 8 | Queried input number, or 0xFF |
| dev_i | input | 5 | Device number for slot mapping |
| intx_i | input | 2 | Device INTx pin |
| line_o | output | 2 | Request line used by that pin |
| rst_wr_i | input | 1 | Reset-control write strobe |
| rst_wdata_i | input | 8 | Reset-control write data |
| rst_rdata_o | output | 8 | Stored reset-control byte |
| sys_rst_req_o | output | 1 | System-reset request pulse |

## Verification
Three kinds of result are due one clock after their stimulus: `irq_o`, the stored routing and reset-control bytes, and the reset-request pulse. The query, slot-mapping and read-data outputs are combinational from state or inputs. The bench drives every input on a falling edge. It then waits out exactly one rising edge and samples on the next falling edge, so each registered result is read in the cycle it first becomes valid. A further check in the following cycle confirms that the reset-request pulse lasts one cycle and no longer.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] route_t;
  localparam route_t ROUTE_OFF = 8'hFF;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned N_LINES    = 4,
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter route_t      RST_VAL    = 8'h80
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [5:0]                addr_i,
  input  logic [N_LINES-1:0]        be_i,
  input  logic [8*N_LINES-1:0]      wdata_i,
  output logic [8*N_LINES-1:0]      rdata_o,
  output logic [N_LINES-1:0][7:0]   route_q_o,
  output logic [N_LINES-1:0][7:0]   route_d_o
);
  logic hit;
  assign hit = (addr_i == ROUTE_BASE[7:2]);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign route_d_o[i] = (wr_i && hit && be_i[i]) ? wdata_i[8*i +: 8] : route_q_o[i];
    assign rdata_o[8*i +: 8] = hit ? route_q_o[i] : 8'h00;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q_o[i] <= RST_VAL;
      else         route_q_o[i] <= route_d_o[i];
    end
  end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned N_IRQ   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LINES-1:0]      req_i,
  input  logic [N_LINES-1:0][7:0] route_i,
  output logic [N_IRQ-1:0]        irq_o
);
  localparam int unsigned MAP_W = N_IRQ * N_LINES;

  logic [MAP_W-1:0] map_d, map_q;

  // bit (irq*N_LINES + line) set when line is high and steered to irq
  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
      assign map_d[k*N_LINES + l] = req_i[l] && (route_i[l] == 8'(k));
    end
    assign irq_o[k] = |map_q[k*N_LINES +: N_LINES];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end
endmodule

// File: rtl/pirq_rst_ctrl.sv
module pirq_rst_ctrl #(
  parameter int unsigned GO_BIT    = 2,
  parameter logic [7:0]  KEEP_MASK = 8'h02
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       req_o
);
  logic go;
  assign go = wdata_i[GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= 8'h00;
      req_o   <= 1'b0;
    end else begin
      req_o <= wr_i && go;
      if (wr_i && !go) rdata_o <= wdata_i & KEEP_MASK;
    end
  end
endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
  parameter int unsigned N_LINES = 4,
  localparam int unsigned LW     = $clog2(N_LINES)
) (
  input  logic [4:0]    dev_i,
  input  logic [LW-1:0] intx_i,
  output logic [LW-1:0] line_o
);
  logic [4:0] sum;
  assign sum    = 5'(intx_i) + dev_i - 5'd1;
  assign line_o = sum[LW-1:0];
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned N_IRQ   = 16,
  localparam int unsigned LW     = $clog2(N_LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_LINES-1:0]     req_i,
  input  logic                   cfg_wr_i,
  input  logic [5:0]             cfg_addr_i,
  input  logic [N_LINES-1:0]     cfg_be_i,
  input  logic [8*N_LINES-1:0]   cfg_wdata_i,
  output logic [8*N_LINES-1:0]   cfg_rdata_o,
  output logic [N_IRQ-1:0]       irq_o,
  input  logic [LW-1:0]          q_pin_i,
  output logic                   q_en_o,
  output logic [7:0]             q_irq_o,
  input  logic [4:0]             dev_i,
  input  logic [LW-1:0]          intx_i,
  output logic [LW-1:0]          line_o,
  input  logic                   rst_wr_i,
  input  logic [7:0]             rst_wdata_i,
  output logic [7:0]             rst_rdata_o,
  output logic                   sys_rst_req_o
);
  logic [N_LINES-1:0][7:0] route_q, route_d;
  route_t q_route;

  pirq_route_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .route_q_o(route_q), .route_d_o(route_d)
  );

  // map uses next routing so outputs settle one clock after a write
  pirq_level_map #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_map (
    .clk_i, .rst_ni, .req_i, .route_i(route_d), .irq_o
  );

  pirq_rst_ctrl u_rst (
    .clk_i, .rst_ni, .wr_i(rst_wr_i), .wdata_i(rst_wdata_i),
    .rdata_o(rst_rdata_o), .req_o(sys_rst_req_o)
  );

  pirq_slot_map #(.N_LINES(N_LINES)) u_slot (
    .dev_i, .intx_i, .line_o
  );

  assign q_route = route_q[q_pin_i];
  assign q_en_o  = q_route < 8'(N_IRQ);
  assign q_irq_o = q_en_o ? q_route : ROUTE_OFF;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned N_IRQ   = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_LINES-1:0]      req_i,
  input logic [N_LINES-1:0][7:0] route_q,
  input logic [N_IRQ-1:0]        irq_o,
  input logic                    cfg_wr_i,
  input logic                    rst_wr_i,
  input logic [7:0]              rst_wdata_i,
  input logic [7:0]              rst_rdata_o,
  input logic                    sys_rst_req_o,
  input logic                    q_en_o,
  input logic [7:0]              q_irq_o
);
  logic [N_LINES-1:0] req_prev;
  logic [N_IRQ-1:0]   exp_irq;
  logic               go_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_prev <= '0;
      go_prev  <= 1'b0;
    end else begin
      req_prev <= req_i;
      go_prev  <= rst_wr_i && ((rst_wdata_i & 8'h04) != 8'h00);
    end
  end

  always_comb begin
    exp_irq = '0;
    for (int k = 0; k < N_IRQ; k++)
      for (int l = 0; l < N_LINES; l++)
        if (req_prev[l] && route_q[l] == 8'(k)) exp_irq[k] = 1'b1;
  end

  p_out_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == exp_irq);

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o == go_prev);

  p_keep_on_go_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_prev |-> $stable(rst_rdata_o));

  p_only_type_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rdata_o & 8'hFD) == 8'h00);

  p_query_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_o |-> q_irq_o == 8'hFF);

  p_route_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(route_q));
endmodule

bind pirq_router pirq_router_chk #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .route_q(route_q),
  .irq_o(irq_o), .cfg_wr_i(cfg_wr_i), .rst_wr_i(rst_wr_i),
  .rst_wdata_i(rst_wdata_i), .rst_rdata_o(rst_rdata_o),
  .sys_rst_req_o(sys_rst_req_o), .q_en_o(q_en_o), .q_irq_o(q_irq_o)
);

// File: tb/sim_pirq_router.sv
module sim_pirq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  req_i = '0;
  logic        cfg_wr_i = 1'b0;
  logic [5:0]  cfg_addr_i = 6'h18;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [15:0] irq_o;
  logic [1:0]  q_pin_i = '0;
  logic        q_en_o;
  logic [7:0]  q_irq_o;
  logic [4:0]  dev_i = '0;
  logic [1:0]  intx_i = '0;
  logic [1:0]  line_o;
  logic        rst_wr_i = 1'b0;
  logic [7:0]  rst_wdata_i = '0;
  logic [7:0]  rst_rdata_o;
  logic        sys_rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] routes [4];

  always #4 clk_i = ~clk_i;

  pirq_router u0 (.*);

  function automatic logic [15:0] model_irq(logic [3:0] req);
    logic [15:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (req[l] && routes[l] < 8'd16) r[routes[l][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] addr, logic [3:0] be, logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_addr_i = addr; cfg_be_i = be; cfg_wdata_i = d;
    if (addr == 6'h18)
      for (int i = 0; i < 4; i++) if (be[i]) routes[i] = d[8*i +: 8];
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_addr_i = 6'h18;
  endtask

  task automatic set_req(logic [3:0] v);
    @(negedge clk_i);
    req_i = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R3 irq", 32'(irq_o), 32'h0);
    chk("R3 routes", cfg_rdata_o, 32'h80808080);
    chk("R8 rst byte", 32'(rst_rdata_o), 32'h0);
    chk("R7 no pulse", 32'(sys_rst_req_o), 32'h0);
    chk("R9 off query", {23'h0, q_en_o, q_irq_o}, {23'h0, 1'b0, 8'hFF});
  endtask

  task automatic t_basic();
    set_req(4'b0001);
    chk("R2 disabled quiet", 32'(irq_o), 32'h0);
    cfg_write(6'h18, 4'b0001, 32'h0000000B);
    chk("R4 route write one clock", 32'(irq_o), 32'h0800);
    chk("R1 readback", cfg_rdata_o, 32'h8080800B);
    set_req(4'b0000);
    chk("R4 level drop", 32'(irq_o), 32'h0);
    q_pin_i = 2'd0; #1;
    chk("R9 query enabled", {23'h0, q_en_o, q_irq_o}, {23'h0, 1'b1, 8'h0B});
  endtask

  task automatic t_shared();
    cfg_write(6'h18, 4'b0011, 32'h00000505);
    set_req(4'b0011);
    chk("R5 both high", 32'(irq_o), 32'(model_irq(4'b0011)));
    set_req(4'b0010);
    chk("R5 one left", 32'(irq_o), 32'h0020);
    set_req(4'b0000);
    chk("R5 both low", 32'(irq_o), 32'h0);
  endtask

  task automatic t_disable();
    cfg_write(6'h18, 4'b0100, 32'h00090000);
    set_req(4'b0100);
    chk("R4 line C", 32'(irq_o), 32'h0200);
    cfg_write(6'h18, 4'b0100, 32'hFF80FFFF);
    chk("R2 disabled while high", 32'(irq_o), 32'h0);
    chk("R1 byte enables", cfg_rdata_o, 32'(model_irq(4'b0) | {routes[3], routes[2], routes[1], routes[0]}));
    cfg_write(6'h18, 4'b0100, 32'h00100000);
    chk("R2 value 16 disables", 32'(irq_o), 32'h0);
    q_pin_i = 2'd2; #1;
    chk("R9 query 16", {23'h0, q_en_o, q_irq_o}, {23'h0, 1'b0, 8'hFF});
    cfg_write(6'h18, 4'b0100, 32'h000F0000);
    chk("R2 value 15 enables", 32'(irq_o), 32'h8000);
    cfg_write(6'h19, 4'b1111, 32'h01010101);
    chk("R1 other dword ignored", 32'(irq_o), 32'h8000);
    cfg_addr_i = 6'h19; #1;
    chk("R1 other dword reads 0", cfg_rdata_o, 32'h0);
    cfg_addr_i = 6'h18;
    set_req(4'b0000);
  endtask

  task automatic t_slot();
    dev_i = 5'd1; intx_i = 2'd0; #1;
    chk("R6 dev1 INTA", 32'(line_o), 32'd0);
    dev_i = 5'd3; intx_i = 2'd2; #1;
    chk("R6 dev3 INTC", 32'(line_o), 32'd0);
    dev_i = 5'd0; intx_i = 2'd0; #1;
    chk("R6 dev0 wrap", 32'(line_o), 32'd3);
    dev_i = 5'd31; intx_i = 2'd3; #1;
    chk("R6 dev31 INTD", 32'(line_o), 32'd1);
  endtask

  task automatic t_rst_port();
    @(negedge clk_i); rst_wr_i = 1'b1; rst_wdata_i = 8'h0B;
    @(negedge clk_i); rst_wr_i = 1'b0;
    chk("R8 keeps bit1", 32'(rst_rdata_o), 32'h02);
    chk("R7 no pulse bit2 clear", 32'(sys_rst_req_o), 32'h0);
    @(negedge clk_i); rst_wr_i = 1'b1; rst_wdata_i = 8'h04;
    @(negedge clk_i); rst_wr_i = 1'b0;
    chk("R7 pulse", 32'(sys_rst_req_o), 32'h1);
    chk("R7 stored unchanged", 32'(rst_rdata_o), 32'h02);
    @(negedge clk_i);
    chk("R7 pulse one cycle", 32'(sys_rst_req_o), 32'h0);
    @(negedge clk_i); rst_wr_i = 1'b1; rst_wdata_i = 8'hF9;
    @(negedge clk_i); rst_wr_i = 1'b0;
    chk("R8 clears bit1", 32'(rst_rdata_o), 32'h00);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) routes[i] = 8'h80;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_basic();
    t_shared();
    t_disable();
    t_slot();
    t_rst_port();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule